// File: doc/BRIEF.md
# Debug Trigger Chain Evaluator

This block turns the raw match results of ten debug triggers into the trap decisions for the instruction in flight. The triggers form five fixed pairs. Trigger 2i and trigger 2i+1 make up pair i. By source the pairs are fetch/fetch, store/store, load/load, fetch/store and fetch/load. A pair may be chained. A chained pair then acts as one AND condition: it fires only when both members match in the same cycle and both ask for the same trap timing. Each trigger has a timing bit. A value of 0 asks for a trap on the current instruction. A value of 1 asks for a trap on the next one.

The comparators sit elsewhere and deliver one match bit per trigger. Trigger settings are loaded through a valid-qualified write port that carries a trigger index. The settings are an enable bit, a timing bit, a two-bit match type, a select bit, an action bit, a chain bit and a 64-bit compare value. A read port returns the stored settings of any trigger. The block raises a current-instruction trap at once. A next-instruction trap is kept in a pending register and presented with the next valid instruction. A pipeline flush discards the pending trap.

Top module: `trig_chain_eval`

## Requirements
- R1: A synchronous active-high reset clears every stored setting, every chain bit and the pending next-instruction trap. After reset, no match produces a trap or a hit.
- R2: An enabled trigger in an unchained pair fires on its own match while `insn_valid` is 1. With timing 0 it raises `trap_now` in the same cycle.
- R3: A disabled trigger never fires. In a chained pair, one disabled member keeps both members from firing.
- R4: When the chain bit of a pair is 1, neither member fires unless both members match in the same cycle.
- R5: When the chain bit of a pair is 1 and the two members' timing bits differ, neither member fires, even if both match.
- R6: The chain bit of pair 1 (triggers 2 and 3, the store/store pair) cannot be set. A write that tries to set it is ignored, it reads back as 0, and the two triggers always act unchained.
- R7: A write with `cfg_valid`=1 and `cfg_idx` below 10 stores all fields of that trigger. The write takes effect from the next cycle. The chain field is taken only from writes to the even member of a pair. Writes with an index of 10 or more change nothing. Reading an index of 10 or more returns zeros. `rd_chain` shows the chain bit of the pair that holds `rd_idx`.
- R8: A fire with timing 1 on a valid instruction sets the pending trap. `trap_next` is 1 in the next cycle that has `insn_valid`=1 and `flush`=0, and the pending trap is cleared at that point. Cycles with no valid instruction keep it waiting.
- R9: `flush`=1 clears the pending trap without presenting it, including a trap that a fire in that same cycle would have set.
- R10: `hit_fetch` is the OR of fires on the fetch-sourced triggers 0, 1, 6 and 8. `hit_mem` is the OR of fires on triggers 2, 3, 4, 5, 7 and 9. `hit_any` is their OR.
- R11: While `insn_valid` is 0, match inputs have no effect: no trap, no hit, and the pending state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Settings write strobe |
| cfg_idx | input | 4 | Trigger index of the write |
| cfg_enable | input | 1 | Enable bit to store |
| cfg_when | input | 1 | Timing bit to store (0 current, 1 next) |
| cfg_mtype | input | 2 | Match type to store |
| cfg_select | input | 1 | Select bit to store |
| cfg_action | input | 1 | Action bit to store |
| cfg_chain | input | 1 | Chain bit (used on even indices) |
| cfg_value | input | 64 | Compare value to store |
| rd_idx | input | 4 | Trigger index to read back |
| rd_enable | output | 1 | Stored enable bit |
| rd_when | output | 1 | Stored timing bit |
| rd_mtype | output | 2 | Stored match type |
| rd_select | output | 1 | Stored select bit |
| rd_action | output | 1 | Stored action bit |
| rd_chain | output | 1 | Chain bit of the pair holding rd_idx |
| rd_value | output | 64 | Stored compare value |
| insn_valid | input | 1 | An instruction is present this cycle |
| flush | input | 1 | Pipeline flush |
| match_vec | input | 10 | Raw match bit per trigger |
| trap_now | output | 1 | Trap on the current instruction |
| trap_next | output | 1 | Deferred trap presented on this instruction |
| hit_fetch | output | 1 | Some fetch-sourced trigger fired |
| hit_mem | output | 1 | Some load/store-sourced trigger fired |
| hit_any | output | 1 | Some trigger fired |

## Verification
The bench aims at the cases where chaining is easy to get wrong. If a chained pair lets one matching member through, the bench sees a spurious trap. If a chained pair does not check timing, the bench sees a trap on a timing clash. If the chain bit of the store/store pair can be set, the bench sees a lone store match go silent and the chain bit read back as 1. Write latency is probed by matching in the same cycle as the enabling write: a design with a same-cycle bypass traps one cycle early. The pending trap is exercised across idle cycles, across flushes, and across an instruction that presents one deferred trap while it sets another. A design that drops, repeats or leaks a deferred trap through a flush shows a wrong `trap_next`.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int TRIG_NUM     = 10;
  localparam int PAIR_NUM     = TRIG_NUM / 2;
  localparam int IDX_W        = $clog2(TRIG_NUM);
  localparam int MTYPE_W      = 2;
  localparam int VAL_W        = 64;
  // pair whose chain bit is hard-wired to zero (store/store)
  localparam int NOCHAIN_PAIR = 1;
  // triggers whose source is the fetch stage: 0, 1, 6, 8
  localparam logic [TRIG_NUM-1:0] FETCH_SRC_MASK = 10'b01_0100_0011;

  typedef enum logic {TM_NOW = 1'b0, TM_NEXT = 1'b1} trap_when_e;

  typedef struct packed {
    logic               enable;
    trap_when_e         when;
    logic [MTYPE_W-1:0] mtype;
    logic               select;
    logic               action;
  } trig_ctl_t;

  // act: per-member qualified match, when: per-member timing
  function automatic logic [1:0] pair_fire(input logic [1:0] act,
                                           input logic [1:0] when,
                                           input logic       chained);
    logic [1:0] res;
    if (!chained) res = act;
    else if (act == 2'b11 && when[0] == when[1]) res = 2'b11;
    else res = 2'b00;
    return res;
  endfunction

  function automatic logic chain_allowed(input int unsigned pair,
                                         input int unsigned nochain);
    return pair != nochain;
  endfunction
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NT      = TRIG_NUM,
  parameter int NP      = NT / 2,
  parameter int IW      = $clog2(NT),
  parameter int VW      = VAL_W,
  parameter int NOCHAIN = NOCHAIN_PAIR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [IW-1:0] wr_idx,
  input  trig_ctl_t     wr_ctl,
  input  logic          wr_chain,
  input  logic [VW-1:0] wr_value,
  input  logic [IW-1:0] rd_idx,
  output logic [NT-1:0] en_vec,
  output logic [NT-1:0] when_vec,
  output logic [NP-1:0] chain_vec,
  output trig_ctl_t     rd_ctl,
  output logic          rd_chain,
  output logic [VW-1:0] rd_value
);
  trig_ctl_t     ctl_q [NT];
  logic [VW-1:0] val_q [NT];

  for (genvar t = 0; t < NT; t++) begin : g_trig
    logic hit_w;
    assign hit_w = wr_valid && (wr_idx == IW'(t));
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[t] <= '0;
        val_q[t] <= '0;
      end else if (hit_w) begin
        ctl_q[t] <= wr_ctl;
        val_q[t] <= wr_value;
      end
    end
    assign en_vec[t]   = ctl_q[t].enable;
    assign when_vec[t] = ctl_q[t].when;
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    if (chain_allowed(p, NOCHAIN)) begin : g_chainable
      logic chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b0;
        else if (wr_valid && (wr_idx == IW'(2 * p))) chain_q <= wr_chain;
      end
      assign chain_vec[p] = chain_q;
    end else begin : g_fixed
      assign chain_vec[p] = 1'b0;
    end
  end

  always_comb begin
    rd_ctl   = '0;
    rd_value = '0;
    rd_chain = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (rd_idx == IW'(t)) begin
        rd_ctl   = ctl_q[t];
        rd_value = val_q[t];
        rd_chain = chain_vec[t / 2];
      end
    end
  end
endmodule

// File: rtl/trig_pair_eval.sv
module trig_pair_eval
  import trig_pkg::*;
(
  input  logic [1:0] act,
  input  logic [1:0] when,
  input  logic       chained,
  output logic [1:0] fire
);
  assign fire = pair_fire(act, when, chained);
endmodule

// File: rtl/trig_pending.sv
module trig_pending (
  input  logic clk,
  input  logic rst,
  input  logic insn_valid,
  input  logic flush,
  input  logic set_req,
  output logic pend_q,
  output logic present
);
  assign present = pend_q && insn_valid && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush)   pend_q <= 1'b0;
    else if (insn_valid) pend_q <= set_req;
  end
endmodule

// File: rtl/trig_chain_eval.sv
module trig_chain_eval
  import trig_pkg::*;
#(
  parameter int NT      = TRIG_NUM,
  parameter int IW      = IDX_W,
  parameter int MW      = MTYPE_W,
  parameter int VW      = VAL_W,
  parameter int NOCHAIN = NOCHAIN_PAIR,
  parameter logic [NT-1:0] FMASK = FETCH_SRC_MASK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_valid,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_enable,
  input  logic          cfg_when,
  input  logic [MW-1:0] cfg_mtype,
  input  logic          cfg_select,
  input  logic          cfg_action,
  input  logic          cfg_chain,
  input  logic [VW-1:0] cfg_value,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_enable,
  output logic          rd_when,
  output logic [MW-1:0] rd_mtype,
  output logic          rd_select,
  output logic          rd_action,
  output logic          rd_chain,
  output logic [VW-1:0] rd_value,
  input  logic          insn_valid,
  input  logic          flush,
  input  logic [NT-1:0] match_vec,
  output logic          trap_now,
  output logic          trap_next,
  output logic          hit_fetch,
  output logic          hit_mem,
  output logic          hit_any
);
  localparam int NP = NT / 2;

  trig_ctl_t     wr_ctl, rd_ctl;
  logic [NT-1:0] en_vec, when_vec, act_vec, fire_vec;
  logic [NP-1:0] chain_vec;
  logic          next_req, pend_q;

  always_comb begin
    wr_ctl        = '0;
    wr_ctl.enable = cfg_enable;
    wr_ctl.when   = trap_when_e'(cfg_when);
    wr_ctl.mtype  = cfg_mtype;
    wr_ctl.select = cfg_select;
    wr_ctl.action = cfg_action;
  end

  trig_cfg_regs #(.NT(NT), .NP(NP), .IW(IW), .VW(VW), .NOCHAIN(NOCHAIN)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_valid(cfg_valid), .wr_idx(cfg_idx), .wr_ctl(wr_ctl),
    .wr_chain(cfg_chain), .wr_value(cfg_value),
    .rd_idx(rd_idx),
    .en_vec(en_vec), .when_vec(when_vec), .chain_vec(chain_vec),
    .rd_ctl(rd_ctl), .rd_chain(rd_chain), .rd_value(rd_value)
  );

  assign rd_enable = rd_ctl.enable;
  assign rd_when   = rd_ctl.when;
  assign rd_mtype  = rd_ctl.mtype;
  assign rd_select = rd_ctl.select;
  assign rd_action = rd_ctl.action;

  assign act_vec = match_vec & en_vec & {NT{insn_valid}};

  for (genvar p = 0; p < NP; p++) begin : g_pair
    trig_pair_eval u_pair (
      .act    (act_vec[2*p+1 -: 2]),
      .when   (when_vec[2*p+1 -: 2]),
      .chained(chain_vec[p]),
      .fire   (fire_vec[2*p+1 -: 2])
    );
  end

  assign trap_now  = |(fire_vec & ~when_vec);
  assign next_req  = |(fire_vec & when_vec);
  assign hit_fetch = |(fire_vec & FMASK);
  assign hit_mem   = |(fire_vec & ~FMASK);
  assign hit_any   = hit_fetch | hit_mem;

  trig_pending u_pend (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .flush(flush),
    .set_req(next_req), .pend_q(pend_q), .present(trap_next)
  );
endmodule

// File: rtl/trig_chain_eval_chk.sv
module trig_chain_eval_chk #(
  parameter int NT      = 10,
  parameter int NOCHAIN = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          insn_valid,
  input logic          flush,
  input logic          trap_now,
  input logic          trap_next,
  input logic          hit_any,
  input logic [NT-1:0] en_vec,
  input logic [NT-1:0] when_vec,
  input logic [NT/2-1:0] chain_vec,
  input logic [NT-1:0] fire_vec,
  input logic          next_req,
  input logic          pend_q
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !pend_q);

  p_nochain_pair_r6: assert property (@(posedge clk) disable iff (rst)
    !chain_vec[NOCHAIN]);

  for (genvar t = 0; t < NT; t++) begin : g_t
    p_disabled_silent_r3: assert property (@(posedge clk) disable iff (rst)
      !en_vec[t] |-> !fire_vec[t]);
  end

  for (genvar p = 0; p < NT / 2; p++) begin : g_p
    p_chain_both_r4: assert property (@(posedge clk) disable iff (rst)
      chain_vec[p] && (fire_vec[2*p] || fire_vec[2*p+1])
        |-> (fire_vec[2*p] && fire_vec[2*p+1]));
    p_timing_clash_r5: assert property (@(posedge clk) disable iff (rst)
      chain_vec[p] && (when_vec[2*p] != when_vec[2*p+1])
        |-> !fire_vec[2*p] && !fire_vec[2*p+1]);
  end

  p_pend_set_r8: assert property (@(posedge clk) disable iff (rst)
    insn_valid && !flush && next_req |=> pend_q);

  p_present_once_r8: assert property (@(posedge clk) disable iff (rst)
    trap_next && !next_req |=> !pend_q);

  p_flush_drop_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pend_q);

  p_hit_source_r10: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> (trap_now || next_req));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |-> !trap_now && !trap_next && !hit_any);
endmodule

bind trig_chain_eval trig_chain_eval_chk #(.NT(NT), .NOCHAIN(NOCHAIN)) u_chk (
  .clk(clk), .rst(rst), .insn_valid(insn_valid), .flush(flush),
  .trap_now(trap_now), .trap_next(trap_next), .hit_any(hit_any),
  .en_vec(en_vec), .when_vec(when_vec), .chain_vec(chain_vec),
  .fire_vec(fire_vec), .next_req(next_req), .pend_q(pend_q)
);

// File: tb/tb_trig_chain_eval.sv
`timescale 1ns/1ps
module tb_trig_chain_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_enable = 1'b0, cfg_when = 1'b0, cfg_select = 1'b0;
  logic        cfg_action = 1'b0, cfg_chain = 1'b0;
  logic [1:0]  cfg_mtype = '0;
  logic [63:0] cfg_value = '0;
  logic [3:0]  rd_idx = '0;
  logic        rd_enable, rd_when, rd_select, rd_action, rd_chain;
  logic [1:0]  rd_mtype;
  logic [63:0] rd_value;
  logic        insn_valid = 1'b0, flush = 1'b0;
  logic [9:0]  match_vec = '0;
  logic        trap_now, trap_next, hit_fetch, hit_mem, hit_any;

  always #2.5 clk = ~clk;

  trig_chain_eval dut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_idx(cfg_idx),
    .cfg_enable(cfg_enable), .cfg_when(cfg_when), .cfg_mtype(cfg_mtype),
    .cfg_select(cfg_select), .cfg_action(cfg_action), .cfg_chain(cfg_chain),
    .cfg_value(cfg_value), .rd_idx(rd_idx), .rd_enable(rd_enable),
    .rd_when(rd_when), .rd_mtype(rd_mtype), .rd_select(rd_select),
    .rd_action(rd_action), .rd_chain(rd_chain), .rd_value(rd_value),
    .insn_valid(insn_valid), .flush(flush), .match_vec(match_vec),
    .trap_now(trap_now), .trap_next(trap_next), .hit_fetch(hit_fetch),
    .hit_mem(hit_mem), .hit_any(hit_any)
  );

  // bench-side model state
  logic        m_en [10];
  logic        m_when [10];
  logic [1:0]  m_mtype [10];
  logic        m_sel [10];
  logic        m_act [10];
  logic [63:0] m_val [10];
  logic        m_chain [5];
  logic        m_pend;
  int n_vec = 0;
  int n_bad = 0;

  function automatic logic is_fetch(input int t);
    return (t == 0) || (t == 1) || (t == 6) || (t == 8);
  endfunction

  task automatic model_clear();
    for (int t = 0; t < 10; t++) begin
      m_en[t] = 0; m_when[t] = 0; m_mtype[t] = 0;
      m_sel[t] = 0; m_act[t] = 0; m_val[t] = 0;
    end
    for (int p = 0; p < 5; p++) m_chain[p] = 0;
    m_pend = 0;
  endtask

  // one clock cycle: optional write, stimulus, comparison, model update
  task automatic cycle(input string tag, input logic [9:0] m, input logic iv,
                       input logic fl, input int ri, input logic wr,
                       input int wi, input logic we, input logic ww,
                       input logic wc, input logic [63:0] wv);
    logic [9:0] fire;
    logic e_now, e_set, e_next, e_fetch, e_mem, e_any;
    logic e_ren, e_rwhen, e_rchain;
    logic [63:0] e_rval;
    @(negedge clk);
    match_vec = m; insn_valid = iv; flush = fl; rd_idx = 4'(ri);
    cfg_valid = wr; cfg_idx = 4'(wi); cfg_enable = we; cfg_when = ww;
    cfg_chain = wc; cfg_value = wv; cfg_mtype = wv[1:0];
    cfg_select = wv[2]; cfg_action = wv[3];
    #1;
    e_now = 0; e_set = 0; e_fetch = 0; e_mem = 0;
    for (int t = 0; t < 10; t++) begin
      logic a, b;
      int q;
      q = (t % 2 == 0) ? t + 1 : t - 1;
      a = iv && m[t] && m_en[t];
      b = iv && m[q] && m_en[q];
      if (m_chain[t / 2]) fire[t] = a && b && (m_when[t] == m_when[q]);
      else fire[t] = a;
      if (fire[t]) begin
        if (m_when[t]) e_set = 1; else e_now = 1;
        if (is_fetch(t)) e_fetch = 1; else e_mem = 1;
      end
    end
    e_any  = e_fetch || e_mem;
    e_next = m_pend && iv && !fl;
    if (ri < 10) begin
      e_ren = m_en[ri]; e_rwhen = m_when[ri]; e_rval = m_val[ri];
      e_rchain = m_chain[ri / 2];
    end else begin
      e_ren = 0; e_rwhen = 0; e_rval = 0; e_rchain = 0;
    end
    n_vec++;
    if (trap_now !== e_now || trap_next !== e_next || hit_fetch !== e_fetch ||
        hit_mem !== e_mem || hit_any !== e_any || rd_enable !== e_ren ||
        rd_when !== e_rwhen || rd_chain !== e_rchain || rd_value !== e_rval) begin
      n_bad++;
      $display("FAIL %s: now %b/%b next %b/%b fetch %b/%b mem %b/%b any %b/%b rd(en,when,chain) %b%b%b/%b%b%b val %h/%h",
               tag, trap_now, e_now, trap_next, e_next, hit_fetch, e_fetch,
               hit_mem, e_mem, hit_any, e_any, rd_enable, rd_when, rd_chain,
               e_ren, e_rwhen, e_rchain, rd_value, e_rval);
    end
    @(posedge clk);
    if (fl) m_pend = 0;
    else if (iv) m_pend = e_set;
    if (wr && wi < 10) begin
      m_en[wi] = we; m_when[wi] = ww; m_val[wi] = wv;
      m_mtype[wi] = wv[1:0]; m_sel[wi] = wv[2]; m_act[wi] = wv[3];
      if (wi % 2 == 0 && wi != 2) m_chain[wi / 2] = wc;
    end
  endtask

  task automatic run(input string tag, input logic [9:0] m, input logic iv,
                     input logic fl, input int ri);
    cycle(tag, m, iv, fl, ri, 0, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic wr(input int wi, input logic we, input logic ww,
                    input logic wc, input logic [63:0] wv);
    cycle("cfg write", 10'h0, 0, 0, wi, 1, wi, we, ww, wc, wv);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, everything disabled
    run("R1 reset state", 10'h3FF, 1, 0, 0);
    run("R1 reset readback", 10'h000, 0, 0, 7);

    // R7: write latency -- match in the same cycle as the enabling write
    cycle("R7 write latency", 10'h001, 1, 0, 0, 1, 0, 1, 0, 0, 64'hA5A5_0000_1234_5678);
    // R2: unchained trigger fires, timing 0
    run("R2 unchained fire", 10'h001, 1, 0, 0);
    // R7: out-of-range index ignored
    wr(10, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R7 index 10 readback", 10'h3FF & ~10'h001, 1, 0, 10);
    run("R7 index 0 readback", 10'h000, 1, 0, 0);

    // R6: store/store pair cannot chain
    wr(2, 1, 0, 1, 64'h22);
    wr(3, 1, 0, 0, 64'h33);
    run("R6 chain reads 0", 10'h004, 1, 0, 2);
    run("R6 lone member fires", 10'h008, 1, 0, 3);

    // R4: chained load/load pair
    wr(4, 1, 0, 1, 64'h44);
    wr(5, 1, 0, 0, 64'h55);
    run("R4 one member only", 10'h010, 1, 0, 4);
    run("R4 other member only", 10'h020, 1, 0, 5);
    run("R4 both members", 10'h030, 1, 0, 5);
    // R5: timing clash
    wr(5, 1, 1, 0, 64'h55);
    run("R5 timing clash", 10'h030, 1, 0, 5);
    // R3: disabled member in chained pair
    wr(5, 0, 0, 0, 64'h55);
    run("R3 disabled member", 10'h030, 1, 0, 5);

    // R8: deferred trap
    wr(8, 1, 1, 0, 64'h88);
    run("R8 set pending", 10'h100, 1, 0, 8);
    run("R8 idle wait", 10'h000, 0, 0, 8);
    run("R8 presented", 10'h000, 1, 0, 8);
    run("R8 cleared", 10'h000, 1, 0, 8);
    run("R8 set again", 10'h100, 1, 0, 8);
    run("R8 present and reset", 10'h100, 1, 0, 8);
    run("R8 second present", 10'h000, 1, 0, 8);
    // R9: flush drops pending
    run("R9 set pending", 10'h100, 1, 0, 8);
    run("R9 flush", 10'h000, 0, 1, 8);
    run("R9 not presented", 10'h000, 1, 0, 8);
    run("R9 flush same cycle", 10'h100, 1, 1, 8);
    run("R9 still empty", 10'h000, 1, 0, 8);
    // R11: matches without a valid instruction
    run("R11 idle matches", 10'h3FF, 0, 0, 4);
    run("R11 no leftover", 10'h000, 1, 0, 4);
    // R10: source split
    wr(7, 1, 0, 0, 64'h77);
    run("R10 mem source", 10'h080, 1, 0, 7);
    run("R10 fetch source", 10'h001, 1, 0, 7);

    // sweep: random settings and matches against the model
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r0, r1, r2;
      logic [63:0] v;
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      v  = {r1, r2};
      if (r0[2:0] == 3'd0)
        cycle("R2 R3 R4 R5 R6 R7 sweep", 10'(r1 | r2), r0[3], 0, int'(r0[7:4] % 12),
              1, int'(r0[11:8] % 12), r0[12] | r0[13], r0[14], r0[15], v);
      else
        run("R8 R9 R10 R11 sweep", 10'(r1 | (r2 & r1 >> 10)), r0[3] | r0[4],
            r0[7:5] == 3'd0, int'(r0[11:8] % 12));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule